// File: doc/BRIEF.md
# Receive Link-Type Classifier and Lookup Key Builder

This block sits on a line card's receive path, in front of an exact-match lookup engine. It watches the header bytes of each incoming Ethernet frame, delivered one byte per beat with start and end markers together with the ingress port number. From the EtherType, the 802.1Q tag and, for IPv4, the protocol number, it decides which of five substrate link kinds the frame came in on. It then builds the lookup key for that kind and the database code that selects the matching table.

One result is produced per frame, after the end marker, on an output with valid/ready handshake. While a result waits to be taken, the byte input is stalled. A frame that fits no rule gets an "unclassified" status. A frame that ends before the fields its kind needs, or whose IPv4 header length is illegal, gets an "error" status. Neither of these two statuses carries a key. The substrate EtherType and the substrate IP protocol number are configuration inputs.

Top module: `lkc_classifier`

## Requirements
- R1: Database codes are fixed per kind. Direct point-to-point uses 4'h0 with a 24-bit key. IPv4 tunnel uses 4'h1 with a 72-bit key. Tagged VLAN0 point-to-point uses 4'h2 with a 24-bit key. Multi-access uses 4'h3 with a 72-bit key. Legacy IPv4 uses 4'h4 with a 24-bit key.
- R2: An untagged frame whose EtherType (bytes 12-13, byte 0 being the first destination-address byte) equals the configured substrate EtherType is a direct link. Its key is the port followed by bytes 14-15, which hold the meta-link identifier.
- R3: A frame with EtherType 0x8100 whose inner type (bytes 16-17) equals the substrate EtherType and whose 12-bit VLAN ID (low 12 bits of bytes 14-15) is zero is a VLAN0 link. Priority bits in the tag do not matter. Its key is the port followed by bytes 18-19.
- R4: The same tagged substrate frame with a non-zero VLAN ID is multi-access. Its key is the port, the source address (bytes 6-11, first byte most significant) and bytes 18-19.
- R5: An untagged frame with EtherType 0x0800 whose protocol byte (byte 23) equals the configured substrate protocol is a tunnel. Its key is the port, 16'h0800, the IP source address (bytes 26-29) and the two bytes that start at offset 14 + 4*IHL, where IHL is the low nibble of byte 14.
- R6: An untagged IPv4 frame with another protocol, or a tagged frame whose inner type is 0x0800, is legacy traffic. Its key is the port followed by 16'h0800.
- R7: Keys are MSB-aligned in the 72-bit output with zeros below the key. out_key_bits gives the key length in bits (24 or 72).
- R8: A frame that matches no rule yields status 2'b01 with key, key length and database code all zero. Status 2'b00 means a key was built.
- R9: A frame that ends before the last byte its kind needs yields status 2'b10 with key, key length and database code all zero. So does a tunnel candidate whose IHL is below 5. A frame that ends exactly on that last byte is classified normally.
- R10: A presented result stays stable until out_ready is seen. in_ready is low while a result is pending.
- R11: The port is taken from in_port on the start beat only. Its value on later beats has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sub_etype | input | 16 | Substrate EtherType value |
| cfg_sub_proto | input | 8 | Substrate IP protocol number |
| in_valid | input | 1 | Byte beat valid |
| in_ready | output | 1 | Block can take a byte |
| in_sof | input | 1 | Beat is the first byte of a frame |
| in_eof | input | 1 | Beat is the last byte of a frame |
| in_data | input | 8 | Frame byte |
| in_port | input | 8 | Ingress port, read on the start beat |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Consumer takes the result |
| out_key | output | 72 | Lookup key, MSB-aligned |
| out_key_bits | output | 7 | Key length in bits, 0 when no key |
| out_db | output | 4 | Database code |
| out_status | output | 2 | 0 ok, 1 unclassified, 2 error |

## Verification
The hardest case to reach is a tunnel whose meta-link identifier moves with the IPv4 header length. The stimulus builds frames with IHL 5 and IHL 6, plus an illegal IHL of 4, so the identifier is read from different offsets. Length boundaries are driven by ending frames one byte short of, and exactly on, the last needed byte. Backpressure is produced by holding out_ready low over several cycles while the bench watches the key and in_ready.

// File: rtl/lkc_pkg.sv
package lkc_pkg;
  localparam int KEY_W  = 72;
  localparam int KBIT_W = $clog2(KEY_W + 1);
  localparam logic [15:0] ET_VLAN = 16'h8100;
  localparam logic [15:0] ET_IPV4 = 16'h0800;

  typedef enum logic [3:0] {
    DB_DIRECT = 4'h0,
    DB_TUNNEL = 4'h1,
    DB_VLAN0  = 4'h2,
    DB_MULTI  = 4'h3,
    DB_LEGACY = 4'h4
  } db_e;

  typedef enum logic [1:0] {
    ST_OK      = 2'b00,
    ST_UNCLASS = 2'b01,
    ST_ERR     = 2'b10
  } st_e;

  typedef struct packed {
    logic [7:0]  port;
    logic [47:0] sa;
    logic [15:0] w12;
    logic [15:0] w14;
    logic [15:0] w16;
    logic [15:0] w18;
    logic [7:0]  proto;
    logic [31:0] ipsa;
    logic [15:0] tmli;
  } cap_t;
endpackage

// File: rtl/lkc_capture.sv
module lkc_capture
  import lkc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [7:0]       in_data,
  input  logic [7:0]       in_port,
  output cap_t             cap,
  output logic [CNT_W-1:0] len,
  output logic             done
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] O6  = CNT_W'(6);
  localparam logic [CNT_W-1:0] O11 = CNT_W'(11);
  localparam logic [CNT_W-1:0] O12 = CNT_W'(12);
  localparam logic [CNT_W-1:0] O13 = CNT_W'(13);
  localparam logic [CNT_W-1:0] O14 = CNT_W'(14);
  localparam logic [CNT_W-1:0] O15 = CNT_W'(15);
  localparam logic [CNT_W-1:0] O16 = CNT_W'(16);
  localparam logic [CNT_W-1:0] O17 = CNT_W'(17);
  localparam logic [CNT_W-1:0] O18 = CNT_W'(18);
  localparam logic [CNT_W-1:0] O19 = CNT_W'(19);
  localparam logic [CNT_W-1:0] O23 = CNT_W'(23);
  localparam logic [CNT_W-1:0] O26 = CNT_W'(26);
  localparam logic [CNT_W-1:0] O29 = CNT_W'(29);

  logic [CNT_W-1:0] cnt_q, cnt_d, off, tm_pos, len_q, len_d;
  cap_t             cap_q, cap_d;
  logic             done_q, done_d;

  always_comb begin
    off    = in_sof ? '0 : cnt_q;
    tm_pos = O14 + CNT_W'({cap_q.w14[11:8], 2'b00});
    cap_d  = cap_q;
    cnt_d  = cnt_q;
    len_d  = len_q;
    done_d = 1'b0;
    if (beat) begin
      cnt_d = (off == CNT_MAX) ? off : off + 1'b1;
      if (in_sof) cap_d.port = in_port;
      if (off >= O6 && off <= O11)   cap_d.sa    = {cap_q.sa[39:0], in_data};
      if (off == O12 || off == O13)  cap_d.w12   = {cap_q.w12[7:0], in_data};
      if (off == O14 || off == O15)  cap_d.w14   = {cap_q.w14[7:0], in_data};
      if (off == O16 || off == O17)  cap_d.w16   = {cap_q.w16[7:0], in_data};
      if (off == O18 || off == O19)  cap_d.w18   = {cap_q.w18[7:0], in_data};
      if (off == O23)                cap_d.proto = in_data;
      if (off >= O26 && off <= O29)  cap_d.ipsa  = {cap_q.ipsa[23:0], in_data};
      if (off == tm_pos || off == tm_pos + 1'b1)
        cap_d.tmli = {cap_q.tmli[7:0], in_data};
      if (in_eof) begin
        done_d = 1'b1;
        len_d  = cnt_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      len_q  <= '0;
      cap_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      cap_q  <= cap_d;
      done_q <= done_d;
    end
  end

  assign cap  = cap_q;
  assign len  = len_q;
  assign done = done_q;
endmodule

// File: rtl/lkc_decide.sv
module lkc_decide
  import lkc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] len,
  input  logic [15:0]      sub_etype,
  input  logic [7:0]       sub_proto,
  input  logic [15:0]      w12,
  input  logic [11:0]      w14_lo,
  input  logic [15:0]      w16,
  input  logic [7:0]       proto,
  output st_e              status,
  output db_e              db
);
  localparam logic [CNT_W-1:0] L14 = CNT_W'(14);
  localparam logic [CNT_W-1:0] L16 = CNT_W'(16);
  localparam logic [CNT_W-1:0] L18 = CNT_W'(18);
  localparam logic [CNT_W-1:0] L20 = CNT_W'(20);
  localparam logic [CNT_W-1:0] L24 = CNT_W'(24);

  logic [3:0]       ihl;
  logic [CNT_W-1:0] tun_need;

  always_comb begin
    ihl      = w14_lo[11:8];
    tun_need = L16 + CNT_W'({ihl, 2'b00});
    status   = ST_UNCLASS;
    db       = DB_DIRECT;
    if (len < L14) begin
      status = ST_ERR;
    end else if (w12 == ET_VLAN) begin
      if (len < L18) begin
        status = ST_ERR;
      end else if (w16 == sub_etype) begin
        if (len < L20) begin
          status = ST_ERR;
        end else begin
          status = ST_OK;
          db     = (w14_lo == 12'h000) ? DB_VLAN0 : DB_MULTI;
        end
      end else if (w16 == ET_IPV4) begin
        status = ST_OK;
        db     = DB_LEGACY;
      end
    end else if (w12 == sub_etype) begin
      if (len < L16) begin
        status = ST_ERR;
      end else begin
        status = ST_OK;
        db     = DB_DIRECT;
      end
    end else if (w12 == ET_IPV4) begin
      if (len < L24) begin
        status = ST_ERR;
      end else if (proto != sub_proto) begin
        status = ST_OK;
        db     = DB_LEGACY;
      end else if (ihl < 4'd5 || len < tun_need) begin
        status = ST_ERR;
      end else begin
        status = ST_OK;
        db     = DB_TUNNEL;
      end
    end
  end
endmodule

// File: rtl/lkc_keypack.sv
module lkc_keypack
  import lkc_pkg::*;
(
  input  st_e               status,
  input  db_e               db,
  input  logic [7:0]        port,
  input  logic [47:0]       sa,
  input  logic [15:0]       w14,
  input  logic [15:0]       w18,
  input  logic [31:0]       ipsa,
  input  logic [15:0]       tmli,
  output logic [KEY_W-1:0]  key,
  output logic [KBIT_W-1:0] key_bits,
  output logic [3:0]        db_code
);
  localparam logic [KBIT_W-1:0] NARROW = KBIT_W'(24);
  localparam logic [KBIT_W-1:0] WIDE   = KBIT_W'(KEY_W);

  always_comb begin
    key      = '0;
    key_bits = '0;
    db_code  = 4'h0;
    if (status == ST_OK) begin
      db_code = db;
      unique case (db)
        DB_DIRECT: begin key = {port, w14, 48'h0};          key_bits = NARROW; end
        DB_VLAN0:  begin key = {port, w18, 48'h0};          key_bits = NARROW; end
        DB_MULTI:  begin key = {port, sa, w18};             key_bits = WIDE;   end
        DB_TUNNEL: begin key = {port, ET_IPV4, ipsa, tmli}; key_bits = WIDE;   end
        DB_LEGACY: begin key = {port, ET_IPV4, 48'h0};      key_bits = NARROW; end
        default:   begin key = '0;                          key_bits = '0;     end
      endcase
    end
  end
endmodule

// File: rtl/lkc_classifier.sv
module lkc_classifier
  import lkc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [15:0]              cfg_sub_etype,
  input  logic [7:0]               cfg_sub_proto,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic                     in_sof,
  input  logic                     in_eof,
  input  logic [7:0]               in_data,
  input  logic [7:0]               in_port,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [lkc_pkg::KEY_W-1:0]  out_key,
  output logic [lkc_pkg::KBIT_W-1:0] out_key_bits,
  output logic [3:0]               out_db,
  output logic [1:0]               out_status
);
  logic [1:0]        rs_q;
  logic              srst_n;
  logic              beat, done;
  cap_t              cap;
  logic [CNT_W-1:0]  len;
  st_e               dec_st;
  db_e               dec_db;
  logic [KEY_W-1:0]  pk_key;
  logic [KBIT_W-1:0] pk_bits;
  logic [3:0]        pk_db;

  logic              vld_q, vld_d;
  logic [KEY_W-1:0]  key_q, key_d;
  logic [KBIT_W-1:0] bits_q, bits_d;
  logic [3:0]        db_q, db_d;
  logic [1:0]        st_q, st_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  assign in_ready = srst_n & ~vld_q & ~done;
  assign beat     = in_valid & in_ready;

  lkc_capture #(.CNT_W(CNT_W)) u_capture (
    .clk(clk), .rst_n(srst_n), .beat(beat), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .in_port(in_port), .cap(cap), .len(len), .done(done)
  );

  lkc_decide #(.CNT_W(CNT_W)) u_decide (
    .len(len), .sub_etype(cfg_sub_etype), .sub_proto(cfg_sub_proto),
    .w12(cap.w12), .w14_lo(cap.w14[11:0]), .w16(cap.w16), .proto(cap.proto),
    .status(dec_st), .db(dec_db)
  );

  lkc_keypack u_keypack (
    .status(dec_st), .db(dec_db), .port(cap.port), .sa(cap.sa), .w14(cap.w14),
    .w18(cap.w18), .ipsa(cap.ipsa), .tmli(cap.tmli),
    .key(pk_key), .key_bits(pk_bits), .db_code(pk_db)
  );

  always_comb begin
    vld_d  = vld_q;
    key_d  = key_q;
    bits_d = bits_q;
    db_d   = db_q;
    st_d   = st_q;
    if (vld_q && out_ready) vld_d = 1'b0;
    if (done) begin
      vld_d  = 1'b1;
      key_d  = pk_key;
      bits_d = pk_bits;
      db_d   = pk_db;
      st_d   = dec_st;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      vld_q  <= 1'b0;
      key_q  <= '0;
      bits_q <= '0;
      db_q   <= '0;
      st_q   <= '0;
    end else begin
      vld_q  <= vld_d;
      key_q  <= key_d;
      bits_q <= bits_d;
      db_q   <= db_d;
      st_q   <= st_d;
    end
  end

  assign out_valid    = vld_q;
  assign out_key      = key_q;
  assign out_key_bits = bits_q;
  assign out_db       = db_q;
  assign out_status   = st_q;
endmodule

// File: rtl/lkc_classifier_chk.sv
module lkc_classifier_chk
  import lkc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [KEY_W-1:0]  out_key,
  input logic [KBIT_W-1:0] out_key_bits,
  input logic [3:0]        out_db,
  input logic [1:0]        out_status
);
  logic ok;
  assign ok = out_valid && (out_status == ST_OK);

  AST_DB_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> out_db <= 4'h4); // R1
  AST_WIDE_KINDS: assert property (@(posedge clk) disable iff (!rst_n)
    ok && (out_db == DB_TUNNEL || out_db == DB_MULTI) |-> out_key_bits == KBIT_W'(72)); // R1
  AST_NARROW_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    ok && !(out_db == DB_TUNNEL || out_db == DB_MULTI) |-> out_key_bits == KBIT_W'(24) && out_key[47:0] == 48'h0); // R7
  AST_TUNNEL_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    ok && out_db == DB_TUNNEL |-> out_key[63:48] == ET_IPV4); // R5
  AST_NO_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_status != ST_OK |-> out_key == '0 && out_key_bits == '0 && out_db == 4'h0); // R8
  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_status != 2'b11); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_key) && $stable(out_db) && $stable(out_status)); // R10
  AST_NO_INTAKE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R10
endmodule

bind lkc_classifier lkc_classifier_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_key(out_key), .out_key_bits(out_key_bits),
  .out_db(out_db), .out_status(out_status)
);

// File: tb/lkc_classifier_bench.sv
module lkc_classifier_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] SUB_ET = 16'h88B5;
  localparam logic [7:0]  SUB_PR = 8'hFD;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cfg_sub_etype;
  logic [7:0]  cfg_sub_proto;
  logic        in_valid, in_sof, in_eof, out_ready;
  logic [7:0]  in_data, in_port;
  logic        in_ready, out_valid;
  logic [71:0] out_key;
  logic [6:0]  out_key_bits;
  logic [3:0]  out_db;
  logic [1:0]  out_status;

  int   errs = 0;
  int   checks = 0;
  bit   finished = 0;
  logic [7:0] fr [0:95];

  always #(CLK_PERIOD/2) clk = ~clk;

  lkc_classifier u_lkc_classifier (
    .clk(clk), .rst_n(rst_n), .cfg_sub_etype(cfg_sub_etype), .cfg_sub_proto(cfg_sub_proto),
    .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .in_port(in_port), .out_valid(out_valid), .out_ready(out_ready),
    .out_key(out_key), .out_key_bits(out_key_bits), .out_db(out_db), .out_status(out_status)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put16(input int o, input logic [15:0] v);
    fr[o] = v[15:8]; fr[o+1] = v[7:0];
  endtask

  task automatic eth(input logic [47:0] sa, input logic [15:0] et);
    for (int i = 0; i < 96; i++) fr[i] = 8'(i * 7 + 3);
    for (int i = 0; i < 6; i++) fr[i] = 8'hFF;
    for (int i = 0; i < 6; i++) fr[6+i] = sa[47-8*i -: 8];
    put16(12, et);
  endtask

  task automatic ipv4(input int base, input logic [3:0] ihl, input logic [7:0] pr, input logic [31:0] src);
    fr[base] = {4'h4, ihl};
    fr[base+9] = pr;
    for (int i = 0; i < 4; i++) fr[base+12+i] = src[31-8*i -: 8];
  endtask

  task automatic send(input int n, input logic [7:0] prt);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == n - 1);
      in_data = fr[i];
      in_port = (i == 0) ? prt : (8'hA5 ^ 8'(i)); // R11: later beats carry noise
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic expect_res(input string req, input logic [1:0] st, input logic [3:0] db,
                            input logic [6:0] bits, input logic [71:0] key);
    int t = 0;
    while (!out_valid && t < 200) begin @(negedge clk); t++; end
    chk(req, {127'h0, out_valid}, 128'h1);
    chk(req, {56'h0, out_key, 2'b00, out_status, out_db, 1'b0, out_key_bits},
             {56'h0, key, 2'b00, st, db, 1'b0, bits});
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(req, {127'h0, out_valid}, 128'h0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 0; in_sof = 0; in_eof = 0; in_data = 0; in_port = 0; out_ready = 0;
    cfg_sub_etype = SUB_ET; cfg_sub_proto = SUB_PR;
    repeat (3) @(negedge clk);
    chk("R10 reset", {126'h0, out_valid, in_ready}, 128'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 idle", {126'h0, out_valid, in_ready}, 128'h1);
  endtask

  task automatic t_direct();
    eth(48'h021122334455, SUB_ET); put16(14, 16'h1234);
    send(30, 8'h05);
    expect_res("R2 direct", 2'b00, 4'h0, 7'd24, {8'h05, 16'h1234, 48'h0});
    send(16, 8'h06); // exact end on last MLI byte
    expect_res("R9 direct exact", 2'b00, 4'h0, 7'd24, {8'h06, 16'h1234, 48'h0});
    send(15, 8'h06);
    expect_res("R9 direct short", 2'b10, 4'h0, 7'd0, 72'h0);
  endtask

  task automatic t_tagged();
    eth(48'h02AABBCCDDEE, 16'h8100); put16(14, 16'hE000); put16(16, SUB_ET); put16(18, 16'hBEEF);
    send(40, 8'h11);
    expect_res("R3 vlan0 prio bits", 2'b00, 4'h2, 7'd24, {8'h11, 16'hBEEF, 48'h0});
    put16(14, 16'h0064); put16(18, 16'h0A0B);
    send(40, 8'h12);
    expect_res("R4 multi-access", 2'b00, 4'h3, 7'd72, {8'h12, 48'h02AABBCCDDEE, 16'h0A0B});
    send(19, 8'h12);
    expect_res("R9 tagged short", 2'b10, 4'h0, 7'd0, 72'h0);
    put16(16, 16'h0800);
    send(40, 8'h13);
    expect_res("R6 legacy tagged", 2'b00, 4'h4, 7'd24, {8'h13, 16'h0800, 48'h0});
    put16(16, 16'h86DD);
    send(40, 8'h13);
    expect_res("R8 tagged unknown", 2'b01, 4'h0, 7'd0, 72'h0);
  endtask

  task automatic t_ip();
    eth(48'h021122334455, 16'h0800); ipv4(14, 4'd5, SUB_PR, 32'hC0A80101); put16(34, 16'h7788);
    send(50, 8'h21);
    expect_res("R5 tunnel ihl5", 2'b00, 4'h1, 7'd72, {8'h21, 16'h0800, 32'hC0A80101, 16'h7788});
    send(36, 8'h21);
    expect_res("R9 tunnel exact", 2'b00, 4'h1, 7'd72, {8'h21, 16'h0800, 32'hC0A80101, 16'h7788});
    send(35, 8'h21);
    expect_res("R9 tunnel short", 2'b10, 4'h0, 7'd0, 72'h0);
    eth(48'h021122334455, 16'h0800); ipv4(14, 4'd6, SUB_PR, 32'h0A000007); put16(38, 16'h4455);
    send(50, 8'h22);
    expect_res("R5 tunnel ihl6", 2'b00, 4'h1, 7'd72, {8'h22, 16'h0800, 32'h0A000007, 16'h4455});
    ipv4(14, 4'd4, SUB_PR, 32'h0A000007);
    send(50, 8'h22);
    expect_res("R9 bad ihl", 2'b10, 4'h0, 7'd0, 72'h0);
    ipv4(14, 4'd5, 8'h06, 32'h0A000007);
    send(60, 8'h23);
    expect_res("R6 legacy untagged", 2'b00, 4'h4, 7'd24, {8'h23, 16'h0800, 48'h0});
  endtask

  task automatic t_unclass();
    eth(48'h021122334455, 16'h86DD);
    send(40, 8'h31);
    expect_res("R8 unknown type", 2'b01, 4'h0, 7'd0, 72'h0);
    send(10, 8'h31);
    expect_res("R9 runt", 2'b10, 4'h0, 7'd0, 72'h0);
    eth(48'h021122334455, SUB_ET); put16(14, 16'h1234);
    cfg_sub_etype = 16'h88B6;
    send(30, 8'h32);
    expect_res("R8 config change", 2'b01, 4'h0, 7'd0, 72'h0);
    cfg_sub_etype = SUB_ET;
  endtask

  task automatic t_backpressure();
    logic [71:0] k0;
    int t = 0;
    eth(48'h021122334455, SUB_ET); put16(14, 16'h5A5A);
    send(20, 8'h41);
    while (!out_valid && t < 200) begin @(negedge clk); t++; end
    k0 = out_key;
    repeat (5) @(negedge clk);
    chk("R10 held", {126'h0, out_valid, in_ready}, 128'h2);
    chk("R10 stable", {56'h0, out_key}, {56'h0, k0});
    expect_res("R1 R7 R11 after hold", 2'b00, 4'h0, 7'd24, {8'h41, 16'h5A5A, 48'h0});
  endtask

  initial begin
    t_reset();
    t_direct();
    t_tagged();
    t_ip();
    t_unclass();
    t_backpressure();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule